// File: doc/BRIEF.md
# Access-Snooping Page Bank Mapper

This block sits on the bus of an 8-bit 6502-style processor inside a cartridge and widens its reach into a larger external memory one 256-byte page at a time. No bank register is written explicitly. The block watches every bus cycle and changes its mapping as a side effect of ordinary loads and stores.

Any access, read or write, to one zero-page address copies the byte seen on the data bus into a page-select latch. A second latch, the stripe select, is loaded from the low address byte of any access inside a 256-byte strobe page. A read in that page also returns a one-hot bit mask, so a single indexed load both fetches a pixel mask and picks the bitmap stripe that holds it. Two 256-byte windows in CPU space are translated into the external extended region through the two latches: one through the page select and one through the stripe select.

A latch takes its new value when phi2 falls, so the new mapping applies from the next bus cycle. Every other address passes through untouched. For those addresses the block neither enables external memory nor drives data.

Top module: `snoop_page_mapper`

## Requirements
- R1: After reset both latches are zero. Address $7C05 maps to external $10005 and $7E33 maps to external $10033.
- R2: A bus cycle with phi2 high at address $00FC, either a read or a write, loads the data byte into the page select.
- R3: While phi2 is high, an address in $7C00–$7CFF drives ext_addr = $10000 + page_select·256 + address[7:0] with ext_ce high. This covers both page edges and page select $FF, which gives $1FFFF.
- R4: A bus cycle, read or write, at an address in $7F00–$7FFF loads the stripe select with address[7:0] shifted right by 3. Low byte 95 gives stripe 11, and 255 gives stripe 31.
- R5: While phi2 is high, an address in $7E00–$7EFF drives ext_addr = $10000 + stripe_select·256 + address[7:0] with ext_ce high.
- R6: A read in $7F00–$7FFF with phi2 high raises rd_oe and returns rd_data = $80 shifted right by address[2:0]. A write there leaves rd_oe low and rd_data at zero.
- R7: Any other address drives ext_addr = {0, address}, with ext_ce, rd_oe and rd_data all zero.
- R8: A latch changes only after phi2 falls on a cycle that was sampled with phi2 high. An address held without a phi2 pulse changes nothing.
- R9: Accesses outside $00FC and $7F00–$7FFF leave both latches unchanged. A read and a later write to the same $7E00-window address, with no strobe access between them, reach the same external address.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than phi2 |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus as observed, driven by the CPU or by memory |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_phi2 | input | 1 | CPU phase-2 clock |
| ext_addr | output | 17 | Address to external memory |
| ext_ce | output | 1 | External memory enable for the two mapped windows |
| rd_data | output | 8 | Mask byte returned on strobe-page reads |
| rd_oe | output | 1 | The block drives rd_data onto the CPU bus |

## Verification
A wrong page-select or stripe-select value cannot be seen on its own. It shows up as a wrong ext_addr bits 15:8 on the first window access after the latch should have changed, which is one bus cycle later. A decode fault in the strobe page shows up at once on rd_oe or rd_data in the same phi2-high phase. A fault in the phi2 edge capture shows up as a latch that changes without a phi2 pulse, or that never changes. The directed tests cover both cases, and they also check that read-modify-write pairs resolve to the same stripe.

// File: rtl/snoop_mapper_pkg.sv
package snoop_mapper_pkg;
  typedef enum logic [2:0] {
    RGN_PASS,
    RGN_SELECT,
    RGN_PAGE_WIN,
    RGN_STRIPE_WIN,
    RGN_STROBE
  } region_e;
endpackage

// File: rtl/snoop_region_dec.sv
module snoop_region_dec
  import snoop_mapper_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int PAGE_BITS    = 8,
  parameter int SELECT_ADDR  = 'h00FC,
  parameter int PAGE_WIN_HI  = 'h7C,
  parameter int STRIPE_WIN_HI = 'h7E,
  parameter int STROBE_HI    = 'h7F
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           rgn
);
  localparam int HI_W = ADDR_W - PAGE_BITS;

  logic [HI_W-1:0] hi;
  assign hi = addr[ADDR_W-1:PAGE_BITS];

  always_comb begin
    if (addr == ADDR_W'(SELECT_ADDR))        rgn = RGN_SELECT;
    else if (hi == HI_W'(PAGE_WIN_HI))       rgn = RGN_PAGE_WIN;
    else if (hi == HI_W'(STRIPE_WIN_HI))     rgn = RGN_STRIPE_WIN;
    else if (hi == HI_W'(STROBE_HI))         rgn = RGN_STROBE;
    else                                     rgn = RGN_PASS;
  end
endmodule

// File: rtl/snoop_bus_capture.sv
module snoop_bus_capture #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              cpu_phi2,
  output logic              commit,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data
);
  logic              phi2_q;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] data_d;

  // snapshot follows the bus only while phi2 is high
  always_comb begin
    addr_d = cap_addr;
    data_d = cap_data;
    if (cpu_phi2) begin
      addr_d = cpu_addr;
      data_d = cpu_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phi2_q   <= 1'b0;
      cap_addr <= '0;
      cap_data <= '0;
    end else begin
      phi2_q   <= cpu_phi2;
      cap_addr <= addr_d;
      cap_data <= data_d;
    end
  end

  assign commit = phi2_q & ~cpu_phi2;
endmodule

// File: rtl/snoop_bank_regs.sv
module snoop_bank_regs
  import snoop_mapper_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int PAGE_BITS    = 8,
  parameter int STRIPE_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  region_e           cap_rgn,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [DATA_W-1:0] cap_data,
  output logic [DATA_W-1:0] page_q,
  output logic [DATA_W-1:0] stripe_q
);
  logic [DATA_W-1:0]    page_d;
  logic [DATA_W-1:0]    stripe_d;
  logic [PAGE_BITS-1:0] strobe_idx;

  assign strobe_idx = cap_addr[PAGE_BITS-1:0] >> STRIPE_SHIFT;

  always_comb begin
    page_d   = page_q;
    stripe_d = stripe_q;
    if (commit) begin
      case (cap_rgn)
        RGN_SELECT: page_d   = cap_data;
        RGN_STROBE: stripe_d = DATA_W'(strobe_idx);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q   <= '0;
      stripe_q <= '0;
    end else begin
      page_q   <= page_d;
      stripe_q <= stripe_d;
    end
  end
endmodule

// File: rtl/snoop_xlate.sv
module snoop_xlate
  import snoop_mapper_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 8,
  parameter int EXT_W     = 1 + DATA_W + PAGE_BITS
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rw,
  input  logic              cpu_phi2,
  input  region_e           rgn,
  input  logic [DATA_W-1:0] page_q,
  input  logic [DATA_W-1:0] stripe_q,
  output logic [EXT_W-1:0]  ext_addr,
  output logic              ext_ce,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] MASK_TOP = {1'b1, {(DATA_W-1){1'b0}}};

  logic [PAGE_BITS-1:0] off;
  assign off = cpu_addr[PAGE_BITS-1:0];

  always_comb begin
    ext_addr = {{(EXT_W-ADDR_W){1'b0}}, cpu_addr};
    ext_ce   = 1'b0;
    case (rgn)
      RGN_PAGE_WIN: begin
        ext_addr = {1'b1, page_q, off};
        ext_ce   = cpu_phi2;
      end
      RGN_STRIPE_WIN: begin
        ext_addr = {1'b1, stripe_q, off};
        ext_ce   = cpu_phi2;
      end
      default: ;
    endcase
  end

  always_comb begin
    rd_oe   = cpu_phi2 & cpu_rw & (rgn == RGN_STROBE);
    rd_data = '0;
    if (rd_oe) rd_data = MASK_TOP >> cpu_addr[IDX_W-1:0];
  end
endmodule

// File: rtl/snoop_page_mapper.sv
module snoop_page_mapper
  import snoop_mapper_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int PAGE_BITS     = 8,
  parameter int STRIPE_SHIFT  = 3,
  parameter int SELECT_ADDR   = 'h00FC,
  parameter int PAGE_WIN_HI   = 'h7C,
  parameter int STRIPE_WIN_HI = 'h7E,
  parameter int STROBE_HI     = 'h7F,
  localparam int EXT_W        = 1 + DATA_W + PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              cpu_rw,
  input  logic              cpu_phi2,
  output logic [EXT_W-1:0]  ext_addr,
  output logic              ext_ce,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe
);
  logic [1:0]        rst_pipe;
  logic              rst_n_sync;
  logic              cap_commit;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  region_e           cap_rgn;
  region_e           cur_rgn;
  logic [DATA_W-1:0] page_q;
  logic [DATA_W-1:0] stripe_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  snoop_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n_sync), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_phi2(cpu_phi2), .commit(cap_commit), .cap_addr(cap_addr), .cap_data(cap_data)
  );

  snoop_region_dec #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .SELECT_ADDR(SELECT_ADDR),
    .PAGE_WIN_HI(PAGE_WIN_HI), .STRIPE_WIN_HI(STRIPE_WIN_HI), .STROBE_HI(STROBE_HI)
  ) u_dec_cap (.addr(cap_addr), .rgn(cap_rgn));

  snoop_region_dec #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .SELECT_ADDR(SELECT_ADDR),
    .PAGE_WIN_HI(PAGE_WIN_HI), .STRIPE_WIN_HI(STRIPE_WIN_HI), .STROBE_HI(STROBE_HI)
  ) u_dec_cur (.addr(cpu_addr), .rgn(cur_rgn));

  snoop_bank_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS), .STRIPE_SHIFT(STRIPE_SHIFT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_sync), .commit(cap_commit), .cap_rgn(cap_rgn),
    .cap_addr(cap_addr), .cap_data(cap_data), .page_q(page_q), .stripe_q(stripe_q)
  );

  snoop_xlate #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS), .EXT_W(EXT_W)
  ) u_xlate (
    .cpu_addr(cpu_addr), .cpu_rw(cpu_rw), .cpu_phi2(cpu_phi2), .rgn(cur_rgn),
    .page_q(page_q), .stripe_q(stripe_q), .ext_addr(ext_addr), .ext_ce(ext_ce),
    .rd_data(rd_data), .rd_oe(rd_oe)
  );
endmodule

// File: rtl/snoop_page_mapper_chk.sv
module snoop_page_mapper_chk #(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int PAGE_BITS    = 8,
  parameter int STRIPE_SHIFT = 3,
  parameter int SELECT_ADDR  = 'h00FC,
  parameter int PAGE_WIN_HI  = 'h7C,
  parameter int STROBE_HI    = 'h7F,
  parameter int EXT_W        = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              commit,
  input logic [ADDR_W-1:0] cap_addr,
  input logic [DATA_W-1:0] cap_data,
  input logic [DATA_W-1:0] page_q,
  input logic [DATA_W-1:0] stripe_q,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_rw,
  input logic              cpu_phi2,
  input logic [EXT_W-1:0]  ext_addr,
  input logic              ext_ce,
  input logic              rd_oe
);
  localparam int HI_W = ADDR_W - PAGE_BITS;

  // R2
  select_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cap_addr == ADDR_W'(SELECT_ADDR)) |=> page_q == $past(cap_data));

  // R4
  strobe_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cap_addr[ADDR_W-1:PAGE_BITS] == HI_W'(STROBE_HI))
      |=> stripe_q == DATA_W'($past(cap_addr[PAGE_BITS-1:0]) >> STRIPE_SHIFT));

  // R8
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(page_q) && $stable(stripe_q)));

  // R6
  mask_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> (cpu_phi2 && cpu_rw && cpu_addr[ADDR_W-1:PAGE_BITS] == HI_W'(STROBE_HI)));

  // R7
  ce_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ce |-> (cpu_phi2 && ext_addr[EXT_W-1]));

  // R3
  page_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_ce && cpu_addr[ADDR_W-1:PAGE_BITS] == HI_W'(PAGE_WIN_HI))
      |-> ext_addr[EXT_W-2:PAGE_BITS] == page_q);
endmodule

bind snoop_page_mapper snoop_page_mapper_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS), .STRIPE_SHIFT(STRIPE_SHIFT),
  .SELECT_ADDR(SELECT_ADDR), .PAGE_WIN_HI(PAGE_WIN_HI), .STROBE_HI(STROBE_HI), .EXT_W(EXT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .commit(cap_commit), .cap_addr(cap_addr),
  .cap_data(cap_data), .page_q(page_q), .stripe_q(stripe_q), .cpu_addr(cpu_addr),
  .cpu_rw(cpu_rw), .cpu_phi2(cpu_phi2), .ext_addr(ext_addr), .ext_ce(ext_ce), .rd_oe(rd_oe)
);

// File: tb/tb_snoop_page_mapper.sv
module tb_snoop_page_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_rw = 1'b1;
  logic        cpu_phi2 = 1'b0;
  logic [16:0] ext_addr;
  logic        ext_ce;
  logic [7:0]  rd_data;
  logic        rd_oe;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  snoop_page_mapper dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_rw(cpu_rw), .cpu_phi2(cpu_phi2), .ext_addr(ext_addr), .ext_ce(ext_ce),
    .rd_data(rd_data), .rd_oe(rd_oe)
  );

  logic [16:0] s_ea;
  logic        s_ce;
  logic [7:0]  s_rd;
  logic        s_oe;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one bus cycle; outputs sampled mid phi2-high, latch commits after phi2 falls
  task automatic bus(input logic [15:0] a, input logic rw, input logic [7:0] d);
    @(posedge clk); #2;
    cpu_phi2 = 1'b0; cpu_addr = a; cpu_rw = rw;
    @(posedge clk); #2;
    cpu_phi2 = 1'b1; cpu_data = d;
    @(posedge clk);
    @(negedge clk);
    s_ea = ext_addr; s_ce = ext_ce; s_rd = rd_data; s_oe = rd_oe;
    @(posedge clk); #2;
    cpu_phi2 = 1'b0;
    @(posedge clk);
  endtask

  task automatic t_reset;
    bus(16'h7C05, 1'b1, 8'h00);
    check("R1 page window", s_ea, 17'h10005);
    check("R1 page ce", s_ce, 1);
    bus(16'h7E33, 1'b1, 8'h00);
    check("R1 stripe window", s_ea, 17'h10033);
  endtask

  task automatic t_select;
    bus(16'h00FC, 1'b0, 8'hA5);
    bus(16'h7C00, 1'b1, 8'h00);
    check("R2 write select / R3 low edge", s_ea, 17'h1A500);
    bus(16'h7CFF, 1'b0, 8'h11);
    check("R3 high edge", s_ea, 17'h1A5FF);
    check("R3 ce", s_ce, 1);
    bus(16'h00FC, 1'b1, 8'h3C);
    bus(16'h7C80, 1'b1, 8'h00);
    check("R2 read select", s_ea, 17'h13C80);
    bus(16'h00FC, 1'b0, 8'hFF);
    bus(16'h7CFF, 1'b1, 8'h00);
    check("R3 top page", s_ea, 17'h1FFFF);
  endtask

  task automatic t_pass;
    bus(16'h1234, 1'b1, 8'h55);
    check("R7 addr", s_ea, 17'h01234);
    check("R7 ce", s_ce, 0);
    check("R7 oe", s_oe, 0);
    check("R7 data", s_rd, 0);
    bus(16'h00FD, 1'b0, 8'h12);
    check("R7 near select", s_ea, 17'h000FD);
    bus(16'h7D00, 1'b0, 8'h34);
    check("R7 between windows ce", s_ce, 0);
    bus(16'h7C01, 1'b1, 8'h00);
    check("R9 select kept", s_ea, 17'h1FF01);
  endtask

  task automatic t_strobe;
    bus(16'h7F5D, 1'b1, 8'h00);
    check("R6 oe", s_oe, 1);
    check("R6 mask", s_rd, 8'h04);
    check("R7 strobe ce", s_ce, 0);
    bus(16'h7E10, 1'b1, 8'h00);
    check("R4 R5 stripe 11", s_ea, 17'h10B10);
    bus(16'h7F5F, 1'b1, 8'h00);
    check("R6 mask lsb", s_rd, 8'h01);
    bus(16'h7F00, 1'b1, 8'h00);
    check("R6 mask msb", s_rd, 8'h80);
    bus(16'h7E00, 1'b0, 8'h00);
    check("R4 stripe 0", s_ea, 17'h10000);
    bus(16'h7FFF, 1'b1, 8'h00);
    bus(16'h7EFF, 1'b1, 8'h00);
    check("R4 R5 stripe 31", s_ea, 17'h11FFF);
    check("R5 ce", s_ce, 1);
    bus(16'h7F28, 1'b0, 8'h99);
    check("R6 write no drive", s_oe, 0);
    check("R6 write data zero", s_rd, 0);
    bus(16'h7E01, 1'b1, 8'h00);
    check("R4 write strobe", s_ea, 17'h10501);
  endtask

  task automatic t_phase;
    @(posedge clk); #2;
    cpu_phi2 = 1'b0; cpu_addr = 16'h00FC; cpu_rw = 1'b0; cpu_data = 8'h77;
    repeat (6) @(posedge clk);
    #2 cpu_addr = 16'h7F48;
    repeat (6) @(posedge clk);
    bus(16'h7C22, 1'b1, 8'h00);
    check("R8 no phi2 select", s_ea, 17'h1FF22);
    bus(16'h7E22, 1'b1, 8'h00);
    check("R8 no phi2 strobe", s_ea, 17'h10522);
  endtask

  task automatic t_rmw;
    logic [16:0] first;
    bus(16'h7F30, 1'b1, 8'h00);
    bus(16'h7E44, 1'b1, 8'h00);
    first = s_ea;
    check("R9 rmw read", s_ea, 17'h10644);
    bus(16'h7C10, 1'b0, 8'h00);
    bus(16'h00FD, 1'b1, 8'h00);
    bus(16'h7E44, 1'b0, 8'h5A);
    check("R9 rmw write same", s_ea, {15'h0, first});
  endtask

  bit done = 1'b0;

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_select();
    t_pass();
    t_strobe();
    t_phase();
    t_rmw();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule